// File: doc/BRIEF.md
# Vector Gather Line Coalescer

This block serves a sixteen-lane vector gather. A requester hands over a base byte address, one unsigned index per lane and a lane enable mask. Each enabled lane reads one 32-bit element at base plus four times its index. The block does not read once per lane. It groups enabled lanes by the 64-byte cache line their element sits in and reads each distinct line once, through a request/response memory port.

One analysis cycle after acceptance counts how many distinct lines the gather needs. The block then walks the lines one at a time. It always picks the line of the lowest-numbered lane still waiting. When that line returns, every waiting lane that lives in it is filled in the same cycle. A gather with good locality therefore costs one memory read, and a fully scattered one costs sixteen.

When the last line has been consumed, a one-cycle completion pulse is raised and the assembled result vector is presented.

Top module: `gather_coalescer`

## Requirements
- R1: After reset, `start_ready_o` is 1, `mem_req_valid_o` and `done_o` are 0, and every lane of `result_o` is zero.
- R2: The byte address of lane i is `base_i + 4*idx[i]`, modulo 2^32, with the index unsigned. Each memory request carries the 64-byte-aligned address of a lane's line, so its low six bits are zero.
- R3: Each gather issues exactly one memory request per distinct line among its enabled lanes. All enabled lanes that share a line are filled from that single response.
- R4: Lines are requested in order of the lowest-numbered enabled lane that has not yet been filled.
- R5: An enabled lane receives bits `[32*w +: 32]` of its line's response data, where w is bits [5:2] of the lane's byte address.
- R6: A lane whose mask bit is 0 keeps the result value it held before the gather and causes no request.
- R7: While `mem_req_valid_o` is 1 and `mem_req_ready_i` is 0, the request stays valid and its address does not change.
- R8: A gather is accepted only when `start_ready_o` is 1. `start_ready_o` is 0 from the cycle after acceptance until the completion pulse.
- R9: `done_o` is high for exactly one cycle. That cycle is the one after the cycle in which the final response was taken, and `result_o` already holds the full result in it.
- R10: A gather with an all-zero mask issues no request and raises `done_o` in the second cycle after acceptance.
- R11: The first request of a non-empty gather appears in the second cycle after acceptance. The cycle in between is spent counting distinct lines.
- R12: At most one request is outstanding. No new request is raised until the response to the previous one has been taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_valid_i | input | 1 | Gather request valid |
| start_ready_o | output | 1 | Block idle, gather can be accepted |
| base_i | input | 32 | Base byte address |
| idx_i | input | 256 | Sixteen 16-bit lane indices, lane i at bits [16*i +: 16] |
| mask_i | input | 16 | Lane enables, bit i for lane i |
| mem_req_valid_o | output | 1 | Line read request valid |
| mem_req_ready_i | input | 1 | Memory accepts the request |
| mem_req_addr_o | output | 32 | Line-aligned byte address |
| mem_rsp_valid_i | input | 1 | Line data valid |
| mem_rsp_data_i | input | 512 | Full line, 32-bit word w at bits [32*w +: 32] |
| done_o | output | 1 | One-cycle gather completion pulse |
| result_o | output | 512 | Result vector, lane i at bits [32*i +: 32] |

## Verification
Two things can happen in the same cycle. Filling several lanes from one response must occur together with keeping the old values of disabled lanes that sit in the very same line. The final fill must also coincide with the completion pulse. The bench provokes both with clustered index patterns: many lanes in one line, some disabled, and a misaligned base that splits lanes across a line boundary. It also uses random stall and response delays. It judges the result by comparing every lane against a model that keeps the previous vector for disabled lanes, and by checking the request order and count against a line list computed from the lane addresses.

// File: rtl/gc_pkg.sv
package gc_pkg;
  typedef enum logic [1:0] {
    GC_IDLE    = 2'd0,
    GC_ANALYZE = 2'd1,
    GC_REQ     = 2'd2,
    GC_RESP    = 2'd3
  } gc_state_e;
endpackage

// File: rtl/gc_addr_gen.sv
module gc_addr_gen #(
  parameter int LANES  = 16,
  parameter int IDX_W  = 16,
  parameter int ADDR_W = 32,
  parameter int SHIFT  = 2,
  parameter int OFF_W  = 6,
  parameter int TAG_W  = ADDR_W - OFF_W,
  parameter int WSEL_W = OFF_W - SHIFT
) (
  input  logic [ADDR_W-1:0]       base_i,
  input  logic [LANES*IDX_W-1:0]  idx_i,
  output logic [LANES*TAG_W-1:0]  tag_o,
  output logic [LANES*WSEL_W-1:0] wsel_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [ADDR_W-1:0] lane_addr;
    assign lane_addr = base_i + (ADDR_W'(idx_i[l*IDX_W +: IDX_W]) << SHIFT);
    assign tag_o[l*TAG_W +: TAG_W]    = lane_addr[ADDR_W-1:OFF_W];
    assign wsel_o[l*WSEL_W +: WSEL_W] = lane_addr[OFF_W-1:SHIFT];
  end
endmodule

// File: rtl/gc_line_scan.sv
module gc_line_scan #(
  parameter int LANES  = 16,
  parameter int TAG_W  = 26,
  parameter int LANE_W = $clog2(LANES),
  parameter int CNT_W  = $clog2(LANES + 1)
) (
  input  logic [LANES*TAG_W-1:0] tag_i,
  input  logic [LANES-1:0]       sel_i,
  output logic                   first_vld_o,
  output logic [TAG_W-1:0]       first_tag_o,
  output logic [LANES-1:0]       hit_o,
  output logic [CNT_W-1:0]       distinct_o
);
  logic [LANE_W-1:0] first_idx;
  logic [LANES-1:0]  leader;

  // lowest-numbered selected lane
  always_comb begin
    first_vld_o = 1'b0;
    first_idx   = '0;
    for (int l = LANES - 1; l >= 0; l--) begin
      if (sel_i[l]) begin
        first_vld_o = 1'b1;
        first_idx   = LANE_W'(l);
      end
    end
  end

  assign first_tag_o = tag_i[first_idx*TAG_W +: TAG_W];

  for (genvar l = 0; l < LANES; l++) begin : g_hit
    assign hit_o[l] = sel_i[l] && (tag_i[l*TAG_W +: TAG_W] == first_tag_o);
  end

  // a lane leads its line when no lower selected lane shares that line
  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      leader[l] = sel_i[l];
      for (int j = 0; j < l; j++) begin
        if (sel_i[j] && (tag_i[j*TAG_W +: TAG_W] == tag_i[l*TAG_W +: TAG_W])) begin
          leader[l] = 1'b0;
        end
      end
    end
  end

  always_comb begin
    distinct_o = '0;
    for (int l = 0; l < LANES; l++) begin
      distinct_o = distinct_o + CNT_W'(leader[l]);
    end
  end
endmodule

// File: rtl/gc_extract.sv
module gc_extract #(
  parameter int LANES  = 16,
  parameter int ELEM_W = 32,
  parameter int LINE_W = 512,
  parameter int WSEL_W = 4,
  parameter int WORDS  = LINE_W / ELEM_W
) (
  input  logic [LINE_W-1:0]       line_i,
  input  logic [LANES*WSEL_W-1:0] wsel_i,
  output logic [LANES*ELEM_W-1:0] elem_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [WSEL_W-1:0] ws;
    logic [ELEM_W-1:0] pick;
    assign ws = wsel_i[l*WSEL_W +: WSEL_W];
    always_comb begin
      pick = '0;
      for (int w = 0; w < WORDS; w++) begin
        if (ws == WSEL_W'(w)) pick = line_i[w*ELEM_W +: ELEM_W];
      end
    end
    assign elem_o[l*ELEM_W +: ELEM_W] = pick;
  end
endmodule

// File: rtl/gather_coalescer.sv
module gather_coalescer #(
  parameter int LANES      = 16,
  parameter int IDX_W      = 16,
  parameter int ADDR_W     = 32,
  parameter int ELEM_W     = 32,
  parameter int LINE_BYTES = 64,
  localparam int LINE_W    = LINE_BYTES * 8,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int SHIFT     = $clog2(ELEM_W / 8),
  localparam int WSEL_W    = OFF_W - SHIFT,
  localparam int TAG_W     = ADDR_W - OFF_W,
  localparam int LANE_W    = $clog2(LANES),
  localparam int CNT_W     = $clog2(LANES + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_valid_i,
  output logic                    start_ready_o,
  input  logic [ADDR_W-1:0]       base_i,
  input  logic [LANES*IDX_W-1:0]  idx_i,
  input  logic [LANES-1:0]        mask_i,
  output logic                    mem_req_valid_o,
  input  logic                    mem_req_ready_i,
  output logic [ADDR_W-1:0]       mem_req_addr_o,
  input  logic                    mem_rsp_valid_i,
  input  logic [LINE_W-1:0]       mem_rsp_data_i,
  output logic                    done_o,
  output logic [LANES*ELEM_W-1:0] result_o
);
  import gc_pkg::*;

  gc_state_e                 state_q, state_d;
  logic [LANES*TAG_W-1:0]    tag_q;
  logic [LANES*WSEL_W-1:0]   wsel_q;
  logic [LANES-1:0]          pend_q, pend_d;
  logic [CNT_W-1:0]          left_q, left_d;
  logic                      done_q, done_d;
  logic [LANES*ELEM_W-1:0]   res_q;

  logic [LANES*TAG_W-1:0]    tag_in;
  logic [LANES*WSEL_W-1:0]   wsel_in;
  logic                      first_vld;
  logic [TAG_W-1:0]          first_tag;
  logic [LANES-1:0]          hit;
  logic [CNT_W-1:0]          distinct;
  logic [LANES*ELEM_W-1:0]   elems;

  logic                      accept;
  logic                      addr_en;
  logic                      fill_en;

  gc_addr_gen #(
    .LANES(LANES), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .SHIFT(SHIFT),
    .OFF_W(OFF_W), .TAG_W(TAG_W), .WSEL_W(WSEL_W)
  ) u_addr (
    .base_i (base_i),
    .idx_i  (idx_i),
    .tag_o  (tag_in),
    .wsel_o (wsel_in)
  );

  gc_line_scan #(
    .LANES(LANES), .TAG_W(TAG_W), .LANE_W(LANE_W), .CNT_W(CNT_W)
  ) u_scan (
    .tag_i       (tag_q),
    .sel_i       (pend_q),
    .first_vld_o (first_vld),
    .first_tag_o (first_tag),
    .hit_o       (hit),
    .distinct_o  (distinct)
  );

  gc_extract #(
    .LANES(LANES), .ELEM_W(ELEM_W), .LINE_W(LINE_W), .WSEL_W(WSEL_W)
  ) u_ext (
    .line_i (mem_rsp_data_i),
    .wsel_i (wsel_q),
    .elem_o (elems)
  );

  assign accept  = (state_q == GC_IDLE) && start_valid_i;
  assign addr_en = accept;
  assign fill_en = (state_q == GC_RESP) && mem_rsp_valid_i;

  // next state
  always_comb begin
    state_d = state_q;
    pend_d  = pend_q;
    left_d  = left_q;
    done_d  = 1'b0;
    case (state_q)
      GC_IDLE: begin
        if (start_valid_i) begin
          pend_d  = mask_i;
          state_d = GC_ANALYZE;
        end
      end
      GC_ANALYZE: begin
        left_d = distinct;
        if (distinct == '0) begin
          done_d  = 1'b1;
          state_d = GC_IDLE;
        end else begin
          state_d = GC_REQ;
        end
      end
      GC_REQ: begin
        if (mem_req_ready_i) state_d = GC_RESP;
      end
      GC_RESP: begin
        if (mem_rsp_valid_i) begin
          pend_d = pend_q & ~hit;
          left_d = left_q - CNT_W'(1);
          if (left_q == CNT_W'(1)) begin
            done_d  = 1'b1;
            state_d = GC_IDLE;
          end else begin
            state_d = GC_REQ;
          end
        end
      end
      default: state_d = GC_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= GC_IDLE;
      pend_q  <= '0;
      left_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      left_q  <= left_d;
      done_q  <= done_d;
    end
  end

  // per-lane address registers, loaded on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q  <= '0;
      wsel_q <= '0;
    end else if (addr_en) begin
      tag_q  <= tag_in;
      wsel_q <= wsel_in;
    end
  end

  // result lanes, each with its own enable
  for (genvar l = 0; l < LANES; l++) begin : g_res
    logic lane_en;
    assign lane_en = fill_en && hit[l];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        res_q[l*ELEM_W +: ELEM_W] <= '0;
      end else if (lane_en) begin
        res_q[l*ELEM_W +: ELEM_W] <= elems[l*ELEM_W +: ELEM_W];
      end
    end
  end

  assign start_ready_o   = (state_q == GC_IDLE);
  assign mem_req_valid_o = (state_q == GC_REQ) && first_vld;
  assign mem_req_addr_o  = {first_tag, {OFF_W{1'b0}}};
  assign done_o          = done_q;
  assign result_o        = res_q;
endmodule

// File: rtl/gc_chk.sv
module gc_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_ready_o,
  input logic              mem_req_valid_o,
  input logic              mem_req_ready_i,
  input logic [ADDR_W-1:0] mem_req_addr_o,
  input logic              mem_rsp_valid_i,
  input logic              done_o
);
  logic outstanding;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outstanding <= 1'b0;
    end else if (mem_req_valid_o && mem_req_ready_i) begin
      outstanding <= 1'b1;
    end else if (mem_rsp_valid_i) begin
      outstanding <= 1'b0;
    end
  end

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid_o && !mem_req_ready_i) |=> (mem_req_valid_o && $stable(mem_req_addr_o)));

  // R8
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid_o |-> !start_ready_o);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R9
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!mem_req_valid_o && start_ready_o));

  // R12
  one_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    outstanding |-> !mem_req_valid_o);

  // R2
  line_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid_o |-> (mem_req_addr_o[5:0] == 6'd0));
endmodule

bind gather_coalescer gc_chk #(.ADDR_W(ADDR_W)) u_gc_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .start_ready_o   (start_ready_o),
  .mem_req_valid_o (mem_req_valid_o),
  .mem_req_ready_i (mem_req_ready_i),
  .mem_req_addr_o  (mem_req_addr_o),
  .mem_rsp_valid_i (mem_rsp_valid_i),
  .done_o          (done_o)
);

// File: tb/tb_gather_coalescer.sv
module tb_gather_coalescer;
  logic         clk;
  logic         rst_n;
  logic         start_valid_i;
  logic         start_ready_o;
  logic [31:0]  base_i;
  logic [255:0] idx_i;
  logic [15:0]  mask_i;
  logic         mem_req_valid_o;
  logic         mem_req_ready_i;
  logic [31:0]  mem_req_addr_o;
  logic         mem_rsp_valid_i;
  logic [511:0] mem_rsp_data_i;
  logic         done_o;
  logic [511:0] result_o;

  int errors = 0;
  int checks = 0;
  logic [31:0] exp_res [16];

  gather_coalescer dut (
    .clk(clk), .rst_n(rst_n),
    .start_valid_i(start_valid_i), .start_ready_o(start_ready_o),
    .base_i(base_i), .idx_i(idx_i), .mask_i(mask_i),
    .mem_req_valid_o(mem_req_valid_o), .mem_req_ready_i(mem_req_ready_i),
    .mem_req_addr_o(mem_req_addr_o),
    .mem_rsp_valid_i(mem_rsp_valid_i), .mem_rsp_data_i(mem_rsp_data_i),
    .done_o(done_o), .result_o(result_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return ((a ^ 32'hA5A5_1234) * 32'h0101_0193) + 32'd7;
  endfunction

  function automatic logic [511:0] mem_line(input logic [31:0] la);
    logic [511:0] d;
    for (int w = 0; w < 16; w++) d[w*32 +: 32] = mem_word(la + 32'(w * 4));
    return d;
  endfunction

  task automatic check32(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run_gather(input logic [31:0] base, input logic [255:0] idx,
                            input logic [15:0] mask);
    logic [31:0] lane_a [16];
    logic [31:0] exp_line [16];
    logic [15:0] pend;
    int n_exp;
    int nreq;
    int guard;
    // expected line order and results
    for (int l = 0; l < 16; l++) lane_a[l] = base + {14'd0, idx[l*16 +: 16], 2'b00};
    pend = mask;
    n_exp = 0;
    while (pend != 16'd0) begin
      int f;
      f = 0;
      for (int l = 15; l >= 0; l--) if (pend[l]) f = l;
      exp_line[n_exp] = {lane_a[f][31:6], 6'd0};
      for (int l = 0; l < 16; l++)
        if (pend[l] && lane_a[l][31:6] == lane_a[f][31:6]) pend[l] = 1'b0;
      n_exp++;
    end
    for (int l = 0; l < 16; l++)
      if (mask[l]) exp_res[l] = mem_word({lane_a[l][31:2], 2'b00});

    check32("R8", "idle ready before start", 32'(start_ready_o), 32'd1);
    start_valid_i = 1'b1;
    base_i = base;
    idx_i  = idx;
    mask_i = mask;
    @(negedge clk);
    start_valid_i = 1'b0;
    check32("R8", "ready low after accept", 32'(start_ready_o), 32'd0);
    nreq = 0;
    if (mask == 16'd0) begin
      check32("R10", "done low in analysis cycle", 32'(done_o), 32'd0);
      @(negedge clk);
      check32("R10", "done in second cycle", 32'(done_o), 32'd1);
      check32("R10", "no request", 32'(mem_req_valid_o), 32'd0);
    end else begin
      check32("R11", "no request in analysis cycle", 32'(mem_req_valid_o), 32'd0);
      @(negedge clk);
      check32("R11", "request in second cycle", 32'(mem_req_valid_o), 32'd1);
      guard = 0;
      while (!done_o && guard < 2000) begin
        if (mem_req_valid_o) begin
          logic [31:0] a;
          int st;
          int dl;
          a = mem_req_addr_o;
          if (nreq < 16)
            check32("R4", "request line order", a, exp_line[nreq]);
          st = int'($urandom % 3);
          mem_req_ready_i = 1'b0;
          for (int s = 0; s < st; s++) begin
            @(negedge clk);
            check32("R7", "held valid", 32'(mem_req_valid_o), 32'd1);
            check32("R7", "held address", mem_req_addr_o, a);
          end
          mem_req_ready_i = 1'b1;
          @(negedge clk);
          mem_req_ready_i = 1'b0;
          dl = int'($urandom % 3);
          for (int s = 0; s < dl; s++) begin
            check32("R12", "no second request", 32'(mem_req_valid_o), 32'd0);
            @(negedge clk);
          end
          mem_rsp_valid_i = 1'b1;
          mem_rsp_data_i  = mem_line(a);
          @(negedge clk);
          mem_rsp_valid_i = 1'b0;
          mem_rsp_data_i  = '0;
          nreq++;
        end else begin
          @(negedge clk);
          guard++;
        end
      end
      check32("R9", "done after final response", 32'(done_o), 32'd1);
    end
    check32("R3", "request count", 32'(nreq), 32'(n_exp));
    for (int l = 0; l < 16; l++)
      check32(mask[l] ? "R5" : "R6", $sformatf("lane %0d", l),
              result_o[l*32 +: 32], exp_res[l]);
    @(negedge clk);
    check32("R9", "done is one cycle", 32'(done_o), 32'd0);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [255:0] ix;
    void'($urandom(32'd4242));
    rst_n = 1'b0;
    start_valid_i = 1'b0;
    base_i = '0;
    idx_i = '0;
    mask_i = '0;
    mem_req_ready_i = 1'b0;
    mem_rsp_valid_i = 1'b0;
    mem_rsp_data_i = '0;
    for (int l = 0; l < 16; l++) exp_res[l] = 32'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check32("R1", "start_ready", 32'(start_ready_o), 32'd1);
    check32("R1", "req_valid", 32'(mem_req_valid_o), 32'd0);
    check32("R1", "done", 32'(done_o), 32'd0);
    for (int l = 0; l < 16; l++) check32("R1", "result zero", result_o[l*32 +: 32], 32'd0);

    // R3: all lanes in one line
    for (int l = 0; l < 16; l++) ix[l*16 +: 16] = 16'(l);
    run_gather(32'h0000_1000, ix, 16'hFFFF);
    // R3: every lane in its own line, reverse order for R4
    for (int l = 0; l < 16; l++) ix[l*16 +: 16] = 16'((15 - l) * 16);
    run_gather(32'h0001_0000, ix, 16'hFFFF);
    // R10 empty mask
    run_gather(32'h0000_2000, ix, 16'h0000);
    // R6 partial mask, shared line
    for (int l = 0; l < 16; l++) ix[l*16 +: 16] = 16'(l ^ 5);
    run_gather(32'h0000_3000, ix, 16'hA5C3);
    // R2 misaligned base splitting a line
    for (int l = 0; l < 16; l++) ix[l*16 +: 16] = 16'(l);
    run_gather(32'h0000_4028, ix, 16'hFFFF);
    // R2 large index with address wrap
    for (int l = 0; l < 16; l++) ix[l*16 +: 16] = 16'hFFFF - 16'(l * 3);
    run_gather(32'hFFFF_0F00, ix, 16'h7FFE);

    for (int t = 0; t < 40; t++) begin
      int mode;
      logic [15:0] m;
      mode = int'($urandom % 3);
      for (int l = 0; l < 16; l++) begin
        if (mode == 0)      ix[l*16 +: 16] = 16'($urandom % 24);
        else if (mode == 1) ix[l*16 +: 16] = 16'($urandom);
        else                ix[l*16 +: 16] = 16'(($urandom % 4) * 16 + ($urandom % 16));
      end
      m = (t % 5 == 0) ? 16'hFFFF : 16'($urandom);
      run_gather($urandom & 32'hFFFF_FFFC, ix, m);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule